// File: doc/BRIEF.md
# Run-Length Sample Stream Decoder

This block expands a stream of compressed capture words into individual logic samples. Each 36-bit input word is one of two kinds. A data word carries a 34-bit sample value, one bit that asks for a second copy of the sample, and one bit that says an extension word follows. An extension word holds an unsigned count. Twice that count is added to the number of copies of the sample that has just been decoded. The decoder gives out the current sample once per accepted output handshake. It takes in a new word only after every pending copy has been delivered.

A sample limit input caps the total number of samples delivered. When the limit is reached, the output stops, even partway through a run. The done flag then rises and no further words are taken. A synchronous clear puts the decoder back in its initial state so that a new stream can start. Both the input and the output use a valid/ready handshake.

Top module: `rle_expander`

## Requirements
- R1: After reset the block shows no output sample (`smp_valid_o` = 0), is ready for a word (`word_ready_o` = 1, with `limit_i` > 0), has `done_o` = 0, and treats the first word as a data word.
- R2: A data word sets the sample to bits 33:0 of the word. The sample is repeated (bit 34 + 1) times, so once when bit 34 = 0 and twice when bit 34 = 1.
- R3: When bit 35 of a data word is 1, the next accepted word is an extension word. Its full 36-bit value times two is added to the repeat count of that sample. The word after an extension word is again a data word.
- R4: While copies of the current sample remain, `word_ready_o` is 0 and no input word is consumed.
- R5: An offered sample that is not accepted (`smp_ready_i` = 0) stays offered with an unchanged value on the next cycle.
- R6: Delivered samples stop once their number reaches `limit_i`, including in the middle of a run. `done_o` is then 1 and both `smp_valid_o` and `word_ready_o` are 0. A limit of 0 gives no samples at all.
- R7: `clear_i` takes precedence over any handshake in the same cycle. On the next cycle the decoder is in the data-word state with nothing pending and with its delivered-sample count at zero. `limit_i` may be changed only while `clear_i` is 1.
- R8: The repeat counter holds an extension word of any 36-bit value after doubling without wrapping. For example, a data word with bit 34 = 0 followed by extension word 0x8_0000_0001 keeps producing samples up to a limit of 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous restart of decoder and sample count |
| limit_i | input | 32 | Maximum number of samples to deliver |
| word_valid_i | input | 1 | Compressed word offered |
| word_i | input | 36 | Compressed word |
| word_ready_o | output | 1 | Decoder takes the offered word |
| smp_valid_o | output | 1 | Sample offered |
| smp_o | output | 34 | Sample value |
| smp_ready_i | input | 1 | Consumer takes the offered sample |
| done_o | output | 1 | Sample limit reached |

## Verification
Two events can land in the same cycle: the sample handshake that uses up the limit, and a run that still has copies left. Both are provoked by sweeping the limit from zero to past the total expansion of each generated stream. The stop point therefore falls on every sample position, at the start, in the middle and at the end of both short and extended runs. Each sweep point is judged by the number of delivered samples, which must equal the minimum of the limit and the arithmetic expansion total, and by done, valid and ready at the stop. A second collision, clear arriving together with both handshakes, is judged by a following stream whose sample count must start again from zero.

// File: rtl/rle_pkg.sv
`timescale 1ns/1ps
package rle_pkg;
  typedef enum logic {
    MODE_DATA = 1'b0,
    MODE_EXT  = 1'b1
  } rle_mode_e;
endpackage

// File: rtl/rle_field_split.sv
`timescale 1ns/1ps
module rle_field_split #(
  parameter int SMP_W  = 34,
  localparam int WORD_W = SMP_W + 2
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [SMP_W-1:0]  sample_o,
  output logic              twice_o,
  output logic              ext_next_o
);
  assign sample_o   = word_i[SMP_W-1:0];
  assign twice_o    = word_i[SMP_W];
  assign ext_next_o = word_i[SMP_W+1];
endmodule

// File: rtl/rle_run_ctrl.sv
`timescale 1ns/1ps
module rle_run_ctrl
  import rle_pkg::*;
#(
  parameter int SMP_W  = 34,
  localparam int WORD_W = SMP_W + 2,
  localparam int RUN_W  = WORD_W + 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              word_take_i,
  input  logic [SMP_W-1:0]  sample_i,
  input  logic              twice_i,
  input  logic              ext_next_i,
  input  logic [WORD_W-1:0] ext_word_i,
  input  logic              smp_take_i,
  output logic              run_zero_o,
  output logic              in_ext_o,
  output logic [SMP_W-1:0]  sample_o
);
  localparam logic [RUN_W-1:0] RUN_ONE = RUN_W'(1);

  rle_mode_e        mode_q;
  logic [RUN_W-1:0] run_q;
  logic [SMP_W-1:0] sample_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= MODE_DATA;
      run_q    <= '0;
      sample_q <= '0;
    end else if (clear_i) begin
      mode_q <= MODE_DATA;
      run_q  <= '0;
    end else if (word_take_i) begin
      if (mode_q == MODE_DATA) begin
        sample_q <= sample_i;
        run_q    <= RUN_W'(twice_i) + RUN_ONE;
        mode_q   <= ext_next_i ? MODE_EXT : MODE_DATA;
      end else begin
        run_q  <= run_q + RUN_W'({ext_word_i, 1'b0});
        mode_q <= MODE_DATA;
      end
    end else if (smp_take_i) begin
      run_q <= run_q - RUN_ONE;
    end
  end

  assign run_zero_o = (run_q == '0);
  assign in_ext_o   = (mode_q == MODE_EXT);
  assign sample_o   = sample_q;

  // R2
  data_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (word_take_i && !in_ext_o) |=>
      (run_q == RUN_W'($past(twice_i)) + RUN_ONE) && (sample_q == $past(sample_i)));

  // R3
  ext_return_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (word_take_i && in_ext_o) |=> !in_ext_o);

  // R8
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (word_take_i && in_ext_o) |=> ((run_q >> 1) == RUN_W'($past(ext_word_i))) && !run_q[0]);

  // R4
  drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (smp_take_i && !word_take_i) |=> run_q == $past(run_q) - RUN_ONE);

  // R7
  clear_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (run_zero_o && !in_ext_o));
endmodule

// File: rtl/rle_limit.sv
`timescale 1ns/1ps
module rle_limit #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             smp_take_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (clear_i)    cnt_q <= '0;
    else if (smp_take_i) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign done_o = (cnt_q >= limit_i);

  // R6
  cnt_le_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    cnt_q <= limit_i);
endmodule

// File: rtl/rle_expander.sv
`timescale 1ns/1ps
module rle_expander #(
  parameter int SMP_W  = 34,
  parameter int CNT_W  = 32,
  localparam int WORD_W = SMP_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [CNT_W-1:0]  limit_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              word_ready_o,
  output logic              smp_valid_o,
  output logic [SMP_W-1:0]  smp_o,
  input  logic              smp_ready_i,
  output logic              done_o
);
  logic [SMP_W-1:0] f_sample;
  logic             f_twice, f_ext_next;
  logic             run_zero, in_ext, done;
  logic             word_take, smp_take;

  rle_field_split #(.SMP_W(SMP_W)) u_split (
    .word_i     (word_i),
    .sample_o   (f_sample),
    .twice_o    (f_twice),
    .ext_next_o (f_ext_next)
  );

  assign word_ready_o = run_zero && !done;
  assign smp_valid_o  = !run_zero && !done;
  assign word_take    = word_valid_i && word_ready_o && !clear_i;
  assign smp_take     = smp_valid_o && smp_ready_i && !clear_i;
  assign done_o       = done;

  rle_run_ctrl #(.SMP_W(SMP_W)) u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clear_i     (clear_i),
    .word_take_i (word_take),
    .sample_i    (f_sample),
    .twice_i     (f_twice),
    .ext_next_i  (f_ext_next),
    .ext_word_i  (word_i),
    .smp_take_i  (smp_take),
    .run_zero_o  (run_zero),
    .in_ext_o    (in_ext),
    .sample_o    (smp_o)
  );

  rle_limit #(.CNT_W(CNT_W)) u_limit (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .smp_take_i (smp_take),
    .limit_i    (limit_i),
    .done_o     (done)
  );

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni || clear_i)
    (smp_valid_o && !smp_ready_i) |=> (smp_valid_o && $stable(smp_o)));

  // R1
  reset_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !in_ext);
endmodule

// File: tb/tb_rle_expander.sv
`timescale 1ns/1ps
module tb_rle_expander;
  localparam int SMP_W = 34;
  localparam int CNT_W = 32;
  localparam int WORD_W = SMP_W + 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic              rst_ni, clear_i, word_valid_i, smp_ready_i;
  logic [CNT_W-1:0]  limit_i;
  logic [WORD_W-1:0] word_i;
  logic              word_ready_o, smp_valid_o, done_o;
  logic [SMP_W-1:0]  smp_o;

  rle_expander #(.SMP_W(SMP_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i), .limit_i(limit_i),
    .word_valid_i(word_valid_i), .word_i(word_i), .word_ready_o(word_ready_o),
    .smp_valid_o(smp_valid_o), .smp_o(smp_o), .smp_ready_i(smp_ready_i),
    .done_o(done_o)
  );

  int checks = 0;
  int fails = 0;
  bit reported = 0;

  logic [WORD_W-1:0] words[32];
  int                nwords;
  logic [SMP_W-1:0]  exp_s[64];
  int                nexp;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  // stream of data words, some followed by extension words (R2, R3)
  task automatic build_stream(input int scen);
    logic ext_mode;
    logic [SMP_W-1:0] last;
    nwords = 0;
    for (int i = 0; i < 6; i++) begin
      logic [SMP_W-1:0] v;
      logic tw, fo;
      v  = {2'(scen), 32'(i) * 32'h9E37_79B9 + 32'(scen)};
      tw = ((i + scen) % 2) == 1;
      fo = ((i + scen) % 3) == 0;
      words[nwords] = {fo, tw, v};
      nwords++;
      if (fo) begin
        words[nwords] = WORD_W'((i + scen) % 4);
        nwords++;
      end
    end
    nexp = 0;
    ext_mode = 0;
    last = '0;
    for (int j = 0; j < nwords; j++) begin
      int n;
      if (ext_mode) begin
        n = 2 * int'(words[j]);
        ext_mode = 0;
      end else begin
        last = words[j][SMP_W-1:0];
        n = int'(words[j][SMP_W]) + 1;
        ext_mode = words[j][SMP_W+1];
      end
      for (int k = 0; k < n; k++) begin
        exp_s[nexp] = last;
        nexp++;
      end
    end
  endtask

  task automatic restart(input int limit);
    @(negedge clk);
    clear_i = 1; limit_i = CNT_W'(limit); word_valid_i = 0; smp_ready_i = 0;
    @(negedge clk);
    clear_i = 0;
  endtask

  task automatic run_once(input int limit);
    int wi, si, expn;
    bit held_v;
    logic [SMP_W-1:0] held;
    wi = 0; si = 0; held_v = 0; held = '0;
    restart(limit);
    for (int cyc = 0; cyc < 400; cyc++) begin
      if (held_v)  // R5
        chk(smp_valid_o && smp_o == held, "R5 hold", 64'(smp_o), 64'(held));
      if (done_o || (wi >= nwords && word_ready_o)) break;
      word_valid_i = (wi < nwords) && (cyc % 4 != 3);
      word_i = (wi < nwords) ? words[wi] : '0;
      smp_ready_i = ((cyc * 5 + limit) % 7) > 1;
      if (smp_valid_o)  // R4
        chk(!word_ready_o, "R4 busy", 64'(word_ready_o), 64'(0));
      if (word_valid_i && word_ready_o) wi++;
      if (smp_valid_o && smp_ready_i) begin
        // R2 R3
        chk(si < nexp && smp_o == exp_s[si], "R2/R3 sample", 64'(smp_o),
            64'(si < nexp ? exp_s[si] : '0));
        si++;
      end
      held_v = smp_valid_o && !smp_ready_i;
      held = smp_o;
      @(negedge clk);
    end
    expn = (limit < nexp) ? limit : nexp;
    // R6
    chk(si == expn, "R6 count", 64'(si), 64'(expn));
    chk(done_o == (limit <= nexp), "R6 done", 64'(done_o), 64'(limit <= nexp));
    if (done_o)
      chk(!smp_valid_o && !word_ready_o, "R6 stopped", {62'd0, smp_valid_o, word_ready_o}, 64'd0);
  endtask

  initial begin
    #900us;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    int cnt;
    rst_ni = 0; clear_i = 0; limit_i = 5; word_valid_i = 0; word_i = '0; smp_ready_i = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1
    chk(!smp_valid_o, "R1 valid", 64'(smp_valid_o), 64'(0));
    chk(word_ready_o, "R1 ready", 64'(word_ready_o), 64'(1));
    chk(!done_o, "R1 done", 64'(done_o), 64'(0));
    // R1: first word is decoded as data
    word_valid_i = 1; word_i = {2'b00, 34'h1_0000_00AB};
    @(negedge clk);
    word_valid_i = 0; smp_ready_i = 1;
    chk(smp_valid_o && smp_o == 34'h1_0000_00AB, "R1 first data", 64'(smp_o), 64'h1_0000_00AB);

    // limit sweep over several streams (R2 R3 R4 R5 R6)
    for (int scen = 0; scen < 6; scen++) begin
      build_stream(scen);
      for (int lim = 0; lim <= nexp + 1; lim++) run_once(lim);
    end

    // R7: clear together with both handshakes
    build_stream(1);
    restart(1000);
    word_valid_i = 1; word_i = words[0]; smp_ready_i = 1;
    for (int c = 0; c < 20 && !smp_valid_o; c++) @(negedge clk);
    repeat (2) @(negedge clk);
    clear_i = 1; limit_i = 2; word_valid_i = 1; word_i = {2'b10, 34'h0_DEAD_0001};
    @(negedge clk);
    clear_i = 0; word_valid_i = 0; smp_ready_i = 0;
    chk(!smp_valid_o, "R7 valid", 64'(smp_valid_o), 64'(0));
    chk(word_ready_o, "R7 ready", 64'(word_ready_o), 64'(1));
    chk(!done_o, "R7 done", 64'(done_o), 64'(0));
    word_valid_i = 1; word_i = {2'b01, 34'h1_2345_6789};
    @(negedge clk);
    word_valid_i = 0; smp_ready_i = 1;
    cnt = 0;
    for (int c = 0; c < 10 && !done_o; c++) begin
      if (smp_valid_o) begin
        chk(smp_o == 34'h1_2345_6789, "R7 sample", 64'(smp_o), 64'h1_2345_6789);
        cnt++;
      end
      @(negedge clk);
    end
    chk(cnt == 2 && done_o, "R7 count restart", 64'(cnt), 64'd2);

    // R8: wide extension word
    restart(20);
    smp_ready_i = 1;
    word_valid_i = 1; word_i = {2'b10, 34'h3_0000_000A};
    @(negedge clk);
    word_valid_i = 1; word_i = 36'h8_0000_0001;
    cnt = 0;
    for (int c = 0; c < 60 && !done_o; c++) begin
      if (word_ready_o && word_valid_i) begin
        @(negedge clk);
        word_valid_i = 0;
        continue;
      end
      if (smp_valid_o) cnt++;
      @(negedge clk);
    end
    chk(cnt == 20 && done_o, "R8 wide run", 64'(cnt), 64'd20);

    report();
  end
endmodule